// File: doc/BRIEF.md
# Ordered Multi-Domain Reset Release Sequencer

This block gathers four reset requests (power-on, watchdog, software and warm) and drives one active-low reset output per clock domain. Any request pulls the affected outputs low at once, with no clock needed. Release then follows a fixed dependency chain that runs on a sequencer clock:

1. Wait until the PLL reports lock.
2. Release the power-management domain.
3. Release the memory-controller domain.
4. Release the CPU domain and every switchable domain together.

Each output is the last stage of a two-flop chain clocked by its own domain clock, so every domain leaves reset on one of its own clock edges. Each step waits for the previous domain's release to come back through a synchronizer. It then waits a programmable number of sequencer cycles, never fewer than four, before it grants the next step.

Watchdog and power-on requests restart the whole chain. Warm and software requests leave the power-management domain running and replay only the later steps. Loss of PLL lock pulls every domain back into reset and returns to the lock wait. A sticky cause register and a sequence-complete flag give the state to the rest of the chip.

Top module: `reset_release_sequencer`

## Requirements
- R1: While any of `por_req`, `wdog_req`, `sw_req` or `warm_req` is high, the memory, CPU and switchable outputs are low, and `seq_done` is low. Both take effect without any clock edge.
- R2: A domain output rises only at a rising edge of that domain's own clock, through a two-flop stage clocked by it.
- R3: No domain output is released while the synchronized PLL lock is low.
- R4: The release order is power-management (index 0), then memory controller (index 1), then CPU (index 2) together with the switchable domains (index 3 and up). A later domain is never out of reset while an earlier one is held.
- R5: Between a domain's acknowledged release and the grant for the next step, at least max(`gap_cycles`, 4) sequencer cycles pass. The next domain therefore rises at least that many clock periods after the previous one.
- R6: A software or warm request leaves the power-management output high throughout, and that output is not released again.
- R7: A watchdog or power-on request also pulls the power-management output low, and the full chain runs again from its first step.
- R8: If PLL lock drops, all domain outputs and `seq_done` go low within four sequencer cycles. Once lock returns, the chain restarts from the power-management step.
- R9: `reset_cause` is one-hot: bit 0 power-on, bit 1 watchdog, bit 2 software, bit 3 warm. It holds the source of the most recent request, taken on the rising edge of the synchronized level. When requests rise together, watchdog wins over warm, and warm wins over software. Only `por_req` returns it to the power-on value.
- R10: `seq_done` rises only after every domain output is high. It stays high until the next request or loss of lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_req | input | 1 | Power-on reset request, active high, asynchronous |
| wdog_req | input | 1 | Watchdog reset request, active high, asynchronous |
| sw_req | input | 1 | Software reset request, active high, asynchronous |
| warm_req | input | 1 | Warm reset request, active high, asynchronous |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| gap_cycles | input | GAP_W | Settle gap between release steps, in sequencer cycles (minimum 4 applied) |
| dom_clk | input | 3+NUM_SW | Per-domain clocks: 0 PMU, 1 memory, 2 CPU, 3+ switchable |
| rst_dom_n | output | 3+NUM_SW | Per-domain resets, active low, driven from flops |
| seq_done | output | 1 | Sequence complete |
| reset_cause | output | 4 | Sticky one-hot source of the last reset |

## Verification
Assertion of the domain resets is combinational through the flops' asynchronous clears, so the bench checks R1, R6 and R7 one time unit after it drives a request, before any clock can act. Loss of lock needs two synchronizer edges plus one sequencer register, about three cycles, so R8 is sampled six cycles after lock drops. Release times depend on the relative phases of the domain clocks. The bench therefore time-stamps every rising output and checks the lower bounds of R4 and R5. It polls `seq_done` on falling clock edges with a bounded wait and only then compares the cause and the output levels.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        ST_LOCK,
        ST_ISSUE,
        ST_ACK,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    localparam int DOM_PMU  = 0;
    localparam int DOM_MEM  = 1;
    localparam int DOM_CPU  = 2;
    localparam int MIN_GAP  = 4;
    localparam int CAUSE_W  = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_POR  = 4'b0001;
    localparam logic [CAUSE_W-1:0] CAUSE_WDOG = 4'b0010;
    localparam logic [CAUSE_W-1:0] CAUSE_SW   = 4'b0100;
    localparam logic [CAUSE_W-1:0] CAUSE_WARM = 4'b1000;
endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[0], d};

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q = sh_q[1];
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               por_req,
    input  logic               wdog_req,
    input  logic               sw_req,
    input  logic               warm_req,
    output logic [CAUSE_W-1:0] cause
);
    typedef struct packed {
        logic [2:0]         prev;
        logic [CAUSE_W-1:0] cause;
    } cause_t;

    localparam cause_t CAUSE_RST = '{prev: 3'b000, cause: CAUSE_POR};

    logic [2:0] req_raw, req_s, rise;
    logic       por_n;
    cause_t     cur_q, nxt_d;

    assign por_n   = ~por_req;
    assign req_raw = {warm_req, sw_req, wdog_req};

    for (genvar i = 0; i < 3; i++) begin : g_req_sync
        rstseq_sync2 u_sync (.clk(clk), .arst_n(por_n), .d(req_raw[i]), .q(req_s[i]));
    end

    always_comb begin
        nxt_d      = cur_q;
        rise       = req_s & ~cur_q.prev;
        nxt_d.prev = req_s;
        if (rise[0])      nxt_d.cause = CAUSE_WDOG;
        else if (rise[2]) nxt_d.cause = CAUSE_WARM;
        else if (rise[1]) nxt_d.cause = CAUSE_SW;
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) cur_q <= CAUSE_RST;
        else         cur_q <= nxt_d;
    end

    assign cause = cur_q.cause;
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int NDOM  = 5,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             any_rst,
    input  logic             hard_rst,
    input  logic             lock_s,
    input  logic [NDOM-1:0]  ack,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic [NDOM-1:0]  grant,
    output logic             done
);
    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       stg;
        logic [GAP_W-1:0] cnt;
        logic             g_mem;
        logic             g_late;
        logic             done;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: ST_LOCK, stg: 2'd0, cnt: '0,
                                 g_mem: 1'b0, g_late: 1'b0, done: 1'b0};
    localparam logic [GAP_W-1:0] GAP_FLOOR = GAP_W'(MIN_GAP);

    fsm_t             cur_q, nxt_d;
    logic             pmu_q, pmu_d;
    logic             stage_ok;
    logic [GAP_W-1:0] lim;

    always_comb begin
        nxt_d = cur_q;
        pmu_d = pmu_q;
        lim   = (gap_cfg < GAP_FLOOR) ? GAP_FLOOR : gap_cfg;
        case (cur_q.stg)
            2'd0:    stage_ok = ack[DOM_PMU];
            2'd1:    stage_ok = ack[DOM_MEM];
            default: stage_ok = &ack[NDOM-1:DOM_CPU];
        endcase
        case (cur_q.st)
            ST_LOCK: begin
                if (lock_s) begin
                    nxt_d.stg = pmu_q ? 2'd1 : 2'd0;
                    nxt_d.st  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                case (cur_q.stg)
                    2'd0:    pmu_d        = 1'b1;
                    2'd1:    nxt_d.g_mem  = 1'b1;
                    default: nxt_d.g_late = 1'b1;
                endcase
                nxt_d.st = ST_ACK;
            end
            ST_ACK: begin
                if (stage_ok) begin
                    if (cur_q.stg == 2'd2) begin
                        nxt_d.st   = ST_DONE;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.cnt = '0;
                        nxt_d.st  = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (cur_q.cnt == lim - GAP_W'(1)) begin
                    nxt_d.stg = cur_q.stg + 2'd1;
                    nxt_d.st  = ST_ISSUE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + GAP_W'(1);
                end
            end
            default: ;
        endcase
        if (!lock_s) begin
            nxt_d = FSM_RST;
            pmu_d = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge any_rst) begin
        if (any_rst) cur_q <= FSM_RST;
        else         cur_q <= nxt_d;
    end

    always_ff @(posedge clk or posedge hard_rst) begin
        if (hard_rst) pmu_q <= 1'b0;
        else          pmu_q <= pmu_d;
    end

    assign grant[DOM_PMU]          = pmu_q;
    assign grant[DOM_MEM]          = cur_q.g_mem;
    assign grant[NDOM-1:DOM_CPU]   = {(NDOM-DOM_CPU){cur_q.g_late}};
    assign done                    = cur_q.done;
endmodule

// File: rtl/reset_release_sequencer.sv
module reset_release_sequencer
    import rstseq_pkg::*;
#(
    parameter int NUM_SW = 2,
    parameter int GAP_W  = 8,
    localparam int NDOM  = 3 + NUM_SW
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               wdog_req,
    input  logic               sw_req,
    input  logic               warm_req,
    input  logic               pll_lock,
    input  logic [GAP_W-1:0]   gap_cycles,
    input  logic [NDOM-1:0]    dom_clk,
    output logic [NDOM-1:0]    rst_dom_n,
    output logic               seq_done,
    output logic [CAUSE_W-1:0] reset_cause
);
    logic            hard_rst, any_rst, hard_n, lock_s;
    logic [NDOM-1:0] grant, ack;

    assign hard_rst = por_req | wdog_req;
    assign any_rst  = hard_rst | sw_req | warm_req;
    assign hard_n   = ~hard_rst;

    rstseq_sync2 u_lock_sync (.clk(clk), .arst_n(hard_n), .d(pll_lock), .q(lock_s));

    rstseq_fsm #(.NDOM(NDOM), .GAP_W(GAP_W)) u_fsm (
        .clk     (clk),
        .any_rst (any_rst),
        .hard_rst(hard_rst),
        .lock_s  (lock_s),
        .ack     (ack),
        .gap_cfg (gap_cycles),
        .grant   (grant),
        .done    (seq_done)
    );

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        rstseq_sync2 u_release (.clk(dom_clk[i]), .arst_n(grant[i]), .d(1'b1),         .q(rst_dom_n[i]));
        rstseq_sync2 u_ack     (.clk(clk),        .arst_n(grant[i]), .d(rst_dom_n[i]), .q(ack[i]));
    end

    rstseq_cause u_cause (
        .clk     (clk),
        .por_req (por_req),
        .wdog_req(wdog_req),
        .sw_req  (sw_req),
        .warm_req(warm_req),
        .cause   (reset_cause)
    );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int NDOM = 5
) (
    input logic            clk,
    input logic            por_req,
    input logic            wdog_req,
    input logic            sw_req,
    input logic            warm_req,
    input logic            lock_s,
    input logic [NDOM-1:0] grant,
    input logic [NDOM-1:0] rst_dom_n,
    input logic            seq_done,
    input logic [3:0]      reset_cause
);
    logic any_rst;
    assign any_rst = por_req | wdog_req | sw_req | warm_req;

    AST_REQ_HOLDS_LOW: assert property (@(posedge clk) disable iff (por_req)
        (wdog_req | sw_req | warm_req) |-> (rst_dom_n[NDOM-1:1] == '0) && !seq_done); // R1
    AST_HARD_PMU_LOW: assert property (@(posedge clk) disable iff (por_req)
        wdog_req |-> !rst_dom_n[0]); // R7
    AST_LOCK_GATE: assert property (@(posedge clk) disable iff (any_rst)
        (|grant) |-> (lock_s || $past(lock_s))); // R3
    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (any_rst)
        (!lock_s && $past(!lock_s)) |-> (grant == '0) && !seq_done); // R8
    AST_PMU_FIRST: assert property (@(posedge clk) disable iff (any_rst)
        !rst_dom_n[0] |-> (rst_dom_n[NDOM-1:1] == '0)); // R4
    AST_MEM_BEFORE_CPU: assert property (@(posedge clk) disable iff (any_rst)
        !rst_dom_n[1] |-> (rst_dom_n[NDOM-1:2] == '0)); // R4
    AST_GAP_MEM: assert property (@(posedge clk) disable iff (any_rst)
        $rose(grant[1]) |-> $past(grant[0], 4)); // R5
    AST_GAP_LATE: assert property (@(posedge clk) disable iff (any_rst)
        $rose(grant[2]) |-> $past(grant[1], 4)); // R5
    AST_DONE_ALL_OUT: assert property (@(posedge clk) disable iff (any_rst)
        seq_done |-> (&rst_dom_n)); // R10
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (por_req)
        $onehot(reset_cause)); // R9
endmodule

bind reset_release_sequencer rstseq_chk #(.NDOM(NDOM)) u_chk (
    .clk        (clk),
    .por_req    (por_req),
    .wdog_req   (wdog_req),
    .sw_req     (sw_req),
    .warm_req   (warm_req),
    .lock_s     (lock_s),
    .grant      (grant),
    .rst_dom_n  (rst_dom_n),
    .seq_done   (seq_done),
    .reset_cause(reset_cause)
);

// File: tb/reset_release_sequencer_test.sv
module reset_release_sequencer_test;
    localparam int NSW   = 2;
    localparam int NDOM  = 3 + NSW;
    localparam int GW    = 8;
    localparam int CLK_P = 8;

    logic clk = 1'b0;
    logic por_req = 1'b1, wdog_req = 1'b0, sw_req = 1'b0, warm_req = 1'b0;
    logic pll_lock = 1'b0;
    logic [GW-1:0] gap_cycles = 8'd4;
    logic dc0 = 1'b0, dc1 = 1'b0, dc2 = 1'b0, dc3 = 1'b0, dc4 = 1'b0;
    logic [NDOM-1:0] dom_clk;
    logic [NDOM-1:0] rst_dom_n;
    logic seq_done;
    logic [3:0] reset_cause;

    int  n_cmp = 0, n_bad = 0;
    bit  finished = 0;
    real t_rise [NDOM];
    logic [NDOM-1:0] prev_rst = '0;

    always #(CLK_P/2) clk = ~clk;
    always #5 dc0 = ~dc0;
    always #3 dc1 = ~dc1;
    always #2 dc2 = ~dc2;
    always #7 dc3 = ~dc3;
    always #9 dc4 = ~dc4;
    assign dom_clk = {dc4, dc3, dc2, dc1, dc0};

    reset_release_sequencer #(.NUM_SW(NSW), .GAP_W(GW)) uut (
        .clk(clk), .por_req(por_req), .wdog_req(wdog_req), .sw_req(sw_req),
        .warm_req(warm_req), .pll_lock(pll_lock), .gap_cycles(gap_cycles),
        .dom_clk(dom_clk), .rst_dom_n(rst_dom_n), .seq_done(seq_done),
        .reset_cause(reset_cause)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R2: every release lands on a rising edge of the domain's own clock
    always @(rst_dom_n) begin
        for (int i = 0; i < NDOM; i++) begin
            if (rst_dom_n[i] === 1'b1 && prev_rst[i] !== 1'b1) begin
                t_rise[i] = $realtime;
                check(dom_clk[i] === 1'b1, "R2", "release off own clock edge", longint'(dom_clk[i]), 1);
            end
        end
        prev_rst = rst_dom_n;
    end

    function automatic logic [3:0] exp_cause(input int src);
        return 4'b0001 << src;
    endfunction

    function automatic int eff_gap(input int g);
        return (g < 4) ? 4 : g;
    endfunction

    task automatic drive(input int src, input logic v);
        case (src)
            0: por_req = v;
            1: wdog_req = v;
            2: sw_req = v;
            default: warm_req = v;
        endcase
    endtask

    task automatic clear_stamps();
        for (int i = 0; i < NDOM; i++) t_rise[i] = -1.0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (seq_done === 1'b1) begin
                ok = 1;
                return;
            end
        end
    endtask

    task automatic check_order(input int g, input bit full);
        int lim = eff_gap(g);
        if (full) begin
            check(t_rise[0] >= 0.0, "R7", "pmu re-released", longint'(t_rise[0] >= 0.0), 1);
            check(t_rise[1] - t_rise[0] >= real'(lim * CLK_P), "R5", "pmu->mem gap",
                  longint'(t_rise[1] - t_rise[0]), lim * CLK_P);
        end else begin
            check(t_rise[0] < 0.0, "R6", "pmu not re-released", longint'(t_rise[0] >= 0.0), 0);
        end
        for (int i = 2; i < NDOM; i++) begin
            check(t_rise[1] >= 0.0 && t_rise[i] > t_rise[1], "R4", "mem before late domain",
                  longint'(t_rise[i]), longint'(t_rise[1]));
            check(t_rise[i] - t_rise[1] >= real'(lim * CLK_P), "R5", "mem->late gap",
                  longint'(t_rise[i] - t_rise[1]), lim * CLK_P);
        end
    endtask

    task automatic run_case(input int src, input int g);
        bit ok;
        bit hard = (src <= 1);
        gap_cycles = GW'(g);
        @(negedge clk);
        clear_stamps();
        drive(src, 1'b1);
        #1;
        check(rst_dom_n[NDOM-1:1] == '0, "R1", "later domains low at once", longint'(rst_dom_n), 0);
        check(seq_done == 1'b0, "R1", "done low at once", longint'(seq_done), 0);
        if (hard) check(rst_dom_n[0] == 1'b0, "R7", "pmu low on hard request", longint'(rst_dom_n[0]), 0);
        else      check(rst_dom_n[0] == 1'b1, "R6", "pmu held high on soft request", longint'(rst_dom_n[0]), 1);
        repeat (6) @(negedge clk);
        if (!hard) check(rst_dom_n[0] == 1'b1, "R6", "pmu high while request held", longint'(rst_dom_n[0]), 1);
        drive(src, 1'b0);
        wait_done(ok);
        check(ok, "R10", "seq_done rose", longint'(ok), 1);
        check(&rst_dom_n, "R10", "all released when done", longint'(rst_dom_n), (1 << NDOM) - 1);
        check(reset_cause == exp_cause(src), "R9", "cause", longint'(reset_cause), longint'(exp_cause(src)));
        check_order(g, hard);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        bit ok;
        void'($urandom(32'd2024));
        clear_stamps();
        repeat (5) @(negedge clk);
        check(rst_dom_n == '0, "R7", "reset state outputs", longint'(rst_dom_n), 0);
        check(seq_done == 1'b0, "R10", "reset state done", longint'(seq_done), 0);
        check(reset_cause == 4'b0001, "R9", "reset state cause", longint'(reset_cause), 1);

        // R3: unlocked PLL holds everything
        por_req = 1'b0;
        repeat (100) @(negedge clk);
        check(rst_dom_n == '0, "R3", "no release without lock", longint'(rst_dom_n), 0);
        check(seq_done == 1'b0, "R3", "no done without lock", longint'(seq_done), 0);
        pll_lock = 1'b1;
        wait_done(ok);
        check(ok, "R10", "first sequence done", longint'(ok), 1);
        check_order(4, 1'b1);

        run_case(3, 0);
        run_case(2, 5);
        run_case(1, 3);
        run_case(0, 7);

        // R8: lock loss and recovery
        @(negedge clk);
        pll_lock = 1'b0;
        repeat (6) @(negedge clk);
        check(rst_dom_n == '0, "R8", "all low after lock loss", longint'(rst_dom_n), 0);
        check(seq_done == 1'b0, "R8", "done low after lock loss", longint'(seq_done), 0);
        check(reset_cause == 4'b0001, "R9", "cause unchanged by lock loss", longint'(reset_cause), 1);
        clear_stamps();
        pll_lock = 1'b1;
        wait_done(ok);
        check(ok, "R8", "sequence after relock", longint'(ok), 1);
        check_order(7, 1'b1);

        // R9: simultaneous soft requests, warm wins
        @(negedge clk);
        sw_req = 1'b1;
        warm_req = 1'b1;
        repeat (6) @(negedge clk);
        sw_req = 1'b0;
        warm_req = 1'b0;
        wait_done(ok);
        check(reset_cause == 4'b1000, "R9", "warm beats software", longint'(reset_cause), 8);

        for (int it = 0; it < 12; it++) begin
            run_case(int'($urandom_range(3, 0)), int'($urandom_range(12, 0)));
        end

        run_case(2, 4);
        run_case(0, 4);
        finish_run();
    end
endmodule